// File: doc/BRIEF.md
# Pipeline Operand Bypass and Hazard Control

This block is the hazard-resolution logic of a five-stage in-order pipeline. The stages are instruction fetch, address computation, operand fetch, operate and operand store. It is purely combinational. Each cycle it compares the register sources, and the memory address, of the instructions in the address-computation and operand-fetch stages against the destinations of the older instructions further down the pipe.

A read-after-write conflict would once have frozen the front of the pipe. Here the same detection predicate steers a bypass multiplexer toward the newest copy of the value. That copy is either the result register that feeds the store stage or, if the design is configured for it, the raw ALU output. The residual stall request is raised only where no bypass path reaches the consumer:

- a register written by the operate stage, when the ALU path is disabled;
- any address-base register still being produced by the operand-fetch or operate stage;
- a memory operand that the operate stage is about to store.

The block drives three select codes: the operand A multiplexer, the operand B multiplexer and the address-adder base multiplexer. It also drives one stall line. The register file, ALU, memory and the multiplexers themselves sit outside the block.

Top module: `fwd_unit`

## Requirements
- R1: Select code values are 0 = normal path (register file or memory), 1 = result register in front of the store stage, 2 = ALU output. With no matching producer every select is 0 and `stall` is low.
- R2: If the store-stage instruction is valid, writes a register and its destination equals the register used for operand A, then `opa_sel` is 1 with no stall.
- R3: With `ALU_FWD`=1, a valid register-writing operate-stage instruction whose destination equals the operand A register makes `opa_sel` 2 with no stall.
- R4: When both the operate and store stages match the same source, the operate stage (the younger producer) decides the select.
- R5: A register operand B (`of_uses_b`=1, `of_mem_rd`=0) follows the same rules as operand A on `opb_sel`.
- R6: For a memory operand B (`of_mem_rd`=1), a store-stage memory write to the same address gives `opb_sel`=1. A pending operate-stage memory write to that address raises `stall` with `opb_sel`=0, and it takes priority.
- R7: The address base register is bypassed only from the store stage (`adr_sel`=1). A match against a register-writing operand-fetch or operate-stage instruction raises `stall` with `adr_sel`=0. `adr_sel` is never 2.
- R8: Register number 0 never matches, whatever the producers hold.
- R9: A producer that is invalid or does not write a register (or memory, for R6) never matches. A consumer stage that is invalid or does not use the operand never yields a bypass or a stall.
- R10: With `ALU_FWD`=0, an operate-stage match on a register operand raises `stall` with the select at 0, and no select is ever 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ac_vld | input | 1 | address-computation stage holds a real instruction |
| ac_uses_base | input | 1 | that instruction adds a base register |
| ac_base | input | REG_W | base register number |
| of_vld | input | 1 | operand-fetch stage holds a real instruction |
| of_uses_a | input | 1 | operand A comes from a register |
| of_src_a | input | REG_W | operand A register number |
| of_uses_b | input | 1 | operand B comes from a register |
| of_src_b | input | REG_W | operand B register number |
| of_mem_rd | input | 1 | operand B is read from memory |
| of_addr | input | ADDR_W | memory operand address |
| of_wr_reg | input | 1 | operand-fetch instruction will write a register |
| of_dst | input | REG_W | its destination register |
| op_vld | input | 1 | operate stage holds a real instruction |
| op_wr_reg | input | 1 | operate instruction writes a register |
| op_dst | input | REG_W | its destination register |
| op_wr_mem | input | 1 | operate instruction writes memory |
| op_addr | input | ADDR_W | its memory address |
| os_vld | input | 1 | store stage holds a real instruction |
| os_wr_reg | input | 1 | store instruction writes a register |
| os_dst | input | REG_W | its destination register |
| os_wr_mem | input | 1 | store instruction writes memory |
| os_addr | input | ADDR_W | its memory address |
| opa_sel | output | 2 | operand A source select |
| opb_sel | output | 2 | operand B source select |
| adr_sel | output | 2 | address adder base select |
| stall | output | 1 | hold the front of the pipe this cycle |

## Verification
Some properties are checked on every input change. No select ever chooses the ALU path where that path is absent. Register 0 never diverts operand A. An idle front end never stalls. A same-address pending memory write in the operate stage always stalls.

The priority between two matching producers can only be shown by the bench's directed scenarios. So can the exact code chosen for each producer and the effect of the ALU_FWD setting, which is compared across two instances. The same holds for the qualification by valid and write bits on each side.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_NORMAL = 2'd0,
        SRC_RESULT = 2'd1,
        SRC_ALU    = 2'd2
    } fwd_src_e;

endpackage

// File: rtl/fwd_match.sv
// One comparison between a consumer index and a producer index.
module fwd_match #(
    parameter int W         = 5,
    parameter bit SKIP_ZERO = 1'b1
) (
    input  logic         cons_use,
    input  logic [W-1:0] cons_idx,
    input  logic         prod_ok,
    input  logic [W-1:0] prod_idx,
    output logic         hit
);
    logic same;
    assign same = (cons_idx == prod_idx);

    generate
        if (SKIP_ZERO) begin : g_skip
            assign hit = cons_use && prod_ok && same && (cons_idx != '0);
        end else begin : g_any
            assign hit = cons_use && prod_ok && same;
        end
    endgenerate
endmodule

// File: rtl/fwd_pick.sv
// Youngest-first source selection for one consumer multiplexer.
module fwd_pick #(
    parameter bit ALLOW_YOUNG = 1'b1
) (
    input  logic       hit_young,
    input  logic       hit_old,
    output logic [1:0] sel,
    output logic       need_stall
);
    import fwd_pkg::*;

    fwd_src_e src;

    always_comb begin
        src        = SRC_NORMAL;
        need_stall = 1'b0;
        if (hit_young) begin
            if (ALLOW_YOUNG) begin
                src = SRC_ALU;
            end else begin
                need_stall = 1'b1;
            end
        end else if (hit_old) begin
            src = SRC_RESULT;
        end
    end

    assign sel = src;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int REG_W   = 5,
    parameter int ADDR_W  = 16,
    parameter bit ALU_FWD = 1'b1
) (
    input  logic              ac_vld,
    input  logic              ac_uses_base,
    input  logic [REG_W-1:0]  ac_base,
    input  logic              of_vld,
    input  logic              of_uses_a,
    input  logic [REG_W-1:0]  of_src_a,
    input  logic              of_uses_b,
    input  logic [REG_W-1:0]  of_src_b,
    input  logic              of_mem_rd,
    input  logic [ADDR_W-1:0] of_addr,
    input  logic              of_wr_reg,
    input  logic [REG_W-1:0]  of_dst,
    input  logic              op_vld,
    input  logic              op_wr_reg,
    input  logic [REG_W-1:0]  op_dst,
    input  logic              op_wr_mem,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              os_vld,
    input  logic              os_wr_reg,
    input  logic [REG_W-1:0]  os_dst,
    input  logic              os_wr_mem,
    input  logic [ADDR_W-1:0] os_addr,
    output logic [1:0]        opa_sel,
    output logic [1:0]        opb_sel,
    output logic [1:0]        adr_sel,
    output logic              stall
);
    // producer qualifiers
    logic of_prod, op_prod, os_prod, op_mprod, os_mprod;
    assign of_prod  = of_vld && of_wr_reg;
    assign op_prod  = op_vld && op_wr_reg;
    assign os_prod  = os_vld && os_wr_reg;
    assign op_mprod = op_vld && op_wr_mem;
    assign os_mprod = os_vld && os_wr_mem;

    // consumer qualifiers
    logic use_a, use_rb, use_mb, use_base;
    assign use_a    = of_vld && of_uses_a;
    assign use_rb   = of_vld && of_uses_b && !of_mem_rd;
    assign use_mb   = of_vld && of_mem_rd;
    assign use_base = ac_vld && ac_uses_base;

    // operand A
    logic a_op, a_os, a_stall;
    fwd_match #(.W(REG_W)) u_a_op (.cons_use(use_a), .cons_idx(of_src_a),
        .prod_ok(op_prod), .prod_idx(op_dst), .hit(a_op));
    fwd_match #(.W(REG_W)) u_a_os (.cons_use(use_a), .cons_idx(of_src_a),
        .prod_ok(os_prod), .prod_idx(os_dst), .hit(a_os));
    fwd_pick #(.ALLOW_YOUNG(ALU_FWD)) u_a_pick (.hit_young(a_op), .hit_old(a_os),
        .sel(opa_sel), .need_stall(a_stall));

    // operand B, register flavour
    logic rb_op, rb_os, rb_stall;
    logic [1:0] rb_sel;
    fwd_match #(.W(REG_W)) u_rb_op (.cons_use(use_rb), .cons_idx(of_src_b),
        .prod_ok(op_prod), .prod_idx(op_dst), .hit(rb_op));
    fwd_match #(.W(REG_W)) u_rb_os (.cons_use(use_rb), .cons_idx(of_src_b),
        .prod_ok(os_prod), .prod_idx(os_dst), .hit(rb_os));
    fwd_pick #(.ALLOW_YOUNG(ALU_FWD)) u_rb_pick (.hit_young(rb_op), .hit_old(rb_os),
        .sel(rb_sel), .need_stall(rb_stall));

    // operand B, memory flavour: no bypass from the operate stage
    logic mb_op, mb_os, mb_stall;
    logic [1:0] mb_sel;
    fwd_match #(.W(ADDR_W), .SKIP_ZERO(1'b0)) u_mb_op (.cons_use(use_mb),
        .cons_idx(of_addr), .prod_ok(op_mprod), .prod_idx(op_addr), .hit(mb_op));
    fwd_match #(.W(ADDR_W), .SKIP_ZERO(1'b0)) u_mb_os (.cons_use(use_mb),
        .cons_idx(of_addr), .prod_ok(os_mprod), .prod_idx(os_addr), .hit(mb_os));
    fwd_pick #(.ALLOW_YOUNG(1'b0)) u_mb_pick (.hit_young(mb_op), .hit_old(mb_os),
        .sel(mb_sel), .need_stall(mb_stall));

    assign opb_sel = of_mem_rd ? mb_sel : rb_sel;

    // address adder base: only the result register is reachable
    logic g_of, g_op, g_os, g_stall;
    fwd_match #(.W(REG_W)) u_g_of (.cons_use(use_base), .cons_idx(ac_base),
        .prod_ok(of_prod), .prod_idx(of_dst), .hit(g_of));
    fwd_match #(.W(REG_W)) u_g_op (.cons_use(use_base), .cons_idx(ac_base),
        .prod_ok(op_prod), .prod_idx(op_dst), .hit(g_op));
    fwd_match #(.W(REG_W)) u_g_os (.cons_use(use_base), .cons_idx(ac_base),
        .prod_ok(os_prod), .prod_idx(os_dst), .hit(g_os));
    fwd_pick #(.ALLOW_YOUNG(1'b0)) u_g_pick (.hit_young(g_of || g_op), .hit_old(g_os),
        .sel(adr_sel), .need_stall(g_stall));

    assign stall = a_stall || rb_stall || mb_stall || g_stall;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W   = 5,
    parameter int ADDR_W  = 16,
    parameter bit ALU_FWD = 1'b1
) (
    input logic              ac_vld,
    input logic              of_vld,
    input logic [REG_W-1:0]  of_src_a,
    input logic              of_mem_rd,
    input logic [ADDR_W-1:0] of_addr,
    input logic              op_vld,
    input logic              op_wr_mem,
    input logic [ADDR_W-1:0] op_addr,
    input logic [1:0]        opa_sel,
    input logic [1:0]        opb_sel,
    input logic [1:0]        adr_sel,
    input logic              stall
);
    always_comb begin
        if (!ALU_FWD) begin
            assert_no_alu_path_R10: assert (opa_sel != 2'd2 && opb_sel != 2'd2);
        end
        assert_zero_reg_R8: assert (of_src_a != '0 || opa_sel == 2'd0);
        assert_idle_front_R9: assert (of_vld || ac_vld || !stall);
        assert_mem_pending_R6: assert (!(of_vld && of_mem_rd && op_vld && op_wr_mem
                                         && op_addr == of_addr) || stall);
        assert_adr_src_R7: assert (adr_sel != 2'd2);
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .ALU_FWD(ALU_FWD)) u_chk (
    .ac_vld(ac_vld), .of_vld(of_vld), .of_src_a(of_src_a), .of_mem_rd(of_mem_rd),
    .of_addr(of_addr), .op_vld(op_vld), .op_wr_mem(op_wr_mem), .op_addr(op_addr),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .adr_sel(adr_sel), .stall(stall)
);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
    localparam int RW = 5;
    localparam int AW = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic ac_vld, ac_uses_base;  logic [RW-1:0] ac_base;
    logic of_vld, of_uses_a, of_uses_b, of_mem_rd, of_wr_reg;
    logic [RW-1:0] of_src_a, of_src_b, of_dst;  logic [AW-1:0] of_addr;
    logic op_vld, op_wr_reg, op_wr_mem;  logic [RW-1:0] op_dst;  logic [AW-1:0] op_addr;
    logic os_vld, os_wr_reg, os_wr_mem;  logic [RW-1:0] os_dst;  logic [AW-1:0] os_addr;
    logic [1:0] opa_sel, opb_sel, adr_sel;  logic stall;
    logic [1:0] n_opa, n_opb, n_adr;        logic n_stall;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    fwd_unit #(.REG_W(RW), .ADDR_W(AW), .ALU_FWD(1'b1)) u_fwd_unit (
        .ac_vld, .ac_uses_base, .ac_base, .of_vld, .of_uses_a, .of_src_a,
        .of_uses_b, .of_src_b, .of_mem_rd, .of_addr, .of_wr_reg, .of_dst,
        .op_vld, .op_wr_reg, .op_dst, .op_wr_mem, .op_addr,
        .os_vld, .os_wr_reg, .os_dst, .os_wr_mem, .os_addr,
        .opa_sel, .opb_sel, .adr_sel, .stall);

    fwd_unit #(.REG_W(RW), .ADDR_W(AW), .ALU_FWD(1'b0)) u_fwd_unit_noalu (
        .ac_vld, .ac_uses_base, .ac_base, .of_vld, .of_uses_a, .of_src_a,
        .of_uses_b, .of_src_b, .of_mem_rd, .of_addr, .of_wr_reg, .of_dst,
        .op_vld, .op_wr_reg, .op_dst, .op_wr_mem, .op_addr,
        .os_vld, .os_wr_reg, .os_dst, .os_wr_mem, .os_addr,
        .opa_sel(n_opa), .opb_sel(n_opb), .adr_sel(n_adr), .stall(n_stall));

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle_all();
        {ac_vld, ac_uses_base, of_vld, of_uses_a, of_uses_b, of_mem_rd, of_wr_reg} = '0;
        {op_vld, op_wr_reg, op_wr_mem, os_vld, os_wr_reg, os_wr_mem} = '0;
        ac_base = '0; of_src_a = '0; of_src_b = '0; of_dst = '0; of_addr = '0;
        op_dst = '0; op_addr = '0; os_dst = '0; os_addr = '0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_quiet();      // R1
        idle_all(); settle();
        chk("R1 opa", opa_sel, 0); chk("R1 opb", opb_sel, 0);
        chk("R1 adr", adr_sel, 0); chk("R1 stall", stall, 0);
    endtask

    task automatic t_store_stage_a();   // R2
        idle_all();
        of_vld = 1; of_uses_a = 1; of_src_a = 5'd7;
        os_vld = 1; os_wr_reg = 1; os_dst = 5'd7; settle();
        chk("R2 opa", opa_sel, 1); chk("R2 stall", stall, 0);
        os_dst = 5'd6; settle();
        chk("R1 miss opa", opa_sel, 0);
    endtask

    task automatic t_alu_a();   // R3, R10
        idle_all();
        of_vld = 1; of_uses_a = 1; of_src_a = 5'd3;
        op_vld = 1; op_wr_reg = 1; op_dst = 5'd3; settle();
        chk("R3 opa", opa_sel, 2); chk("R3 stall", stall, 0);
        chk("R10 opa", n_opa, 0); chk("R10 stall", n_stall, 1);
    endtask

    task automatic t_youngest();   // R4
        idle_all();
        of_vld = 1; of_uses_a = 1; of_src_a = 5'd9;
        op_vld = 1; op_wr_reg = 1; op_dst = 5'd9;
        os_vld = 1; os_wr_reg = 1; os_dst = 5'd9; settle();
        chk("R4 opa", opa_sel, 2); chk("R4 noalu stall", n_stall, 1);
        op_wr_reg = 0; settle();
        chk("R9 op no write opa", opa_sel, 1);
    endtask

    task automatic t_reg_b();   // R5
        idle_all();
        of_vld = 1; of_uses_b = 1; of_src_b = 5'd12;
        os_vld = 1; os_wr_reg = 1; os_dst = 5'd12; settle();
        chk("R5 opb result", opb_sel, 1);
        op_vld = 1; op_wr_reg = 1; op_dst = 5'd12; settle();
        chk("R5 opb alu", opb_sel, 2); chk("R5 noalu stall", n_stall, 1);
    endtask

    task automatic t_mem_b();   // R6
        idle_all();
        of_vld = 1; of_mem_rd = 1; of_addr = 16'h0040;
        os_vld = 1; os_wr_mem = 1; os_addr = 16'h0040; settle();
        chk("R6 opb result", opb_sel, 1); chk("R6 no stall", stall, 0);
        op_vld = 1; op_wr_mem = 1; op_addr = 16'h0040; settle();
        chk("R6 stall", stall, 1); chk("R6 opb", opb_sel, 0);
        op_addr = 16'h0041; settle();
        chk("R6 other addr", stall, 0);
    endtask

    task automatic t_addr();   // R7
        idle_all();
        ac_vld = 1; ac_uses_base = 1; ac_base = 5'd4;
        os_vld = 1; os_wr_reg = 1; os_dst = 5'd4; settle();
        chk("R7 adr result", adr_sel, 1); chk("R7 no stall", stall, 0);
        op_vld = 1; op_wr_reg = 1; op_dst = 5'd4; settle();
        chk("R7 op stall", stall, 1); chk("R7 op adr", adr_sel, 0);
        op_vld = 0; of_vld = 1; of_wr_reg = 1; of_dst = 5'd4; settle();
        chk("R7 of stall", stall, 1);
    endtask

    task automatic t_zero();   // R8
        idle_all();
        of_vld = 1; of_uses_a = 1; of_uses_b = 1;
        op_vld = 1; op_wr_reg = 1; os_vld = 1; os_wr_reg = 1; settle();
        chk("R8 opa", opa_sel, 0); chk("R8 opb", opb_sel, 0);
        chk("R8 noalu stall", n_stall, 0);
    endtask

    task automatic t_qualify();   // R9
        idle_all();
        of_uses_a = 1; of_src_a = 5'd2;
        op_vld = 1; op_wr_reg = 1; op_dst = 5'd2; settle();
        chk("R9 invalid consumer opa", opa_sel, 0);
        chk("R9 invalid consumer stall", n_stall, 0);
        of_vld = 1; of_uses_a = 0; settle();
        chk("R9 unused opa", opa_sel, 0);
        of_uses_a = 1; op_vld = 0; settle();
        chk("R9 invalid producer", opa_sel, 0);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_all();
        repeat (2) @(posedge clk);
        t_quiet(); t_store_stage_a(); t_alu_a(); t_youngest(); t_reg_b();
        t_mem_b(); t_addr(); t_zero(); t_qualify();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule